// File: doc/BRIEF.md
# Flash Mode Control and Status Register

This block is one 8-bit control and status register for an on-chip flash controller. Software reaches it at a single decoded address on a simple CPU bus, with address, write strobe, read strobe, write data and read data. Reads are combinational. The register drives the flash engine's mode inputs: a rewrite-mode enable, an enable for rewriting the protected low blocks, a stop (low-power) request and a one-cycle flash reset pulse. In return it reports the engine's ready/busy state and two sticky error flags, one for program and one for erase.

The two mode bits are guarded against stray writes. A guarded bit can only go from 0 to 1 when the write that sets it comes straight after a write to this register that put a 0 in that bit, with no bus access of any kind in between. Idle cycles with no access do not break the sequence. The protected-block enable can only be set while rewrite mode is already on. It drops in the same cycle that rewrite mode is turned off.

The stop bit can always be written and read back. It only drives the low-power request and the reset pulse while rewrite mode is on. The engine sets the error flags with single-cycle strobes and clears both with a clear-status strobe.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset the register reads 0x01 with the engine idle, and rewrite_en, blk_wr_en, stop_req and flash_rst_pulse are all 0.
- R2: The read layout is: bit 0 = NOT eng_busy (1 = ready), bit 1 = rewrite mode, bit 2 = block enable, bit 3 = stop, bit 6 = program error, bit 7 = erase error. Reads are combinational from the current state.
- R3: Bit 1 (rewrite mode) goes from 0 to 1 only when the write follows, as the immediately preceding bus access, a write to this register with bit 1 = 0. A write with bit 1 = 0 always clears it. The register is updated on the clock edge of the write.
- R4: Any bus access (a read, or a write to another address) between the arming write and the setting write breaks the sequence. The guarded bit then keeps its old value.
- R5: Bit 2 (block enable) follows the same arming rule, and it is set only if bit 1 was already 1 before the setting write.
- R6: Whenever bit 1 becomes 0, bit 2 becomes 0 in the same cycle.
- R7: Bit 3 (stop) takes the written value on every write. stop_req equals bit 3 AND bit 1.
- R8: flash_rst_pulse is high for exactly one cycle, in the cycle after the write that takes bit 3 from 0 to 1 while bit 1 is 1 after that write. It stays low otherwise.
- R9: eng_prog_err sets bit 6 and eng_erase_err sets bit 7 on the next edge. eng_clr_status clears both. When a set and a clear arrive in the same cycle, the set wins.
- R10: Bits 5 and 4 always read 0, whatever is written to them.
- R11: A write to any address other than CTL_ADDR changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register |
| eng_busy | input | 1 | Engine is programming or erasing |
| eng_prog_err | input | 1 | One-cycle program error event |
| eng_erase_err | input | 1 | One-cycle erase error event |
| eng_clr_status | input | 1 | Clear-status command strobe |
| rewrite_en | output | 1 | Rewrite mode enable |
| blk_wr_en | output | 1 | Protected low-block rewrite enable |
| stop_req | output | 1 | Low-power stop request |
| flash_rst_pulse | output | 1 | One-cycle flash reset |

## Verification
The bench builds the block with ADDR_W = 8 and CTL_ADDR = 8'h3A. It sends random bus traffic to CTL_ADDR and to addresses one bit away from it. Because of those near-miss addresses, a decoder that drops or ignores one address bit leads to visible writes from the wrong address. Random mixes of reads, foreign writes and idle gaps between the arming and setting writes exercise every way the guard sequence can be broken or kept. Directed steps cover the same-cycle set/clear race and the stop bit written outside rewrite mode.

// File: rtl/fctl_pkg.sv
package fctl_pkg;
  localparam int RDY_B  = 0;
  localparam int RW_B   = 1;
  localparam int BLK_B  = 2;
  localparam int STP_B  = 3;
  localparam int PERR_B = 6;
  localparam int EERR_B = 7;
  localparam int N_GUARD = 2;
  localparam int N_ERR   = 2;
  localparam int DATA_W  = 8;
endpackage

// File: rtl/fctl_guard_bit.sv
module fctl_guard_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic hit_wr,
  input  logic wbit,
  input  logic precond,
  input  logic force_clr,
  output logic q,
  output logic q_next
);
  logic arm_q, arm_n;
  logic upd;

  always_comb begin
    arm_n = arm_q;
    if (hit_wr && !wbit)
      arm_n = 1'b1;
    else if (acc)
      arm_n = 1'b0;
    q_next = q;
    if (hit_wr)
      q_next = wbit ? (q | (arm_q & precond)) : 1'b0;
    if (force_clr)
      q_next = 1'b0;
  end

  assign upd = hit_wr | force_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      q     <= 1'b0;
    end else begin
      if (acc) arm_q <= arm_n;
      if (upd) q     <= q_next;
    end
  end
endmodule

// File: rtl/fctl_sticky.sv
module fctl_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_n;

  always_comb begin
    q_n = q;
    if (clr) q_n = 1'b0;
    if (set) q_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else if (set | clr) q <= q_n;
  end
endmodule

// File: rtl/fctl_stop_unit.sv
module fctl_stop_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_wr,
  input  logic wbit,
  input  logic rw_q,
  input  logic rw_next,
  output logic stop_q,
  output logic stop_req,
  output logic rst_pulse
);
  logic stop_n, pulse_n;

  always_comb begin
    stop_n  = hit_wr ? wbit : stop_q;
    pulse_n = stop_n & ~stop_q & rw_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q    <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      if (hit_wr) stop_q <= stop_n;
      rst_pulse <= pulse_n;
    end
  end

  assign stop_req = stop_q & rw_q;
endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_prog_err,
  input  logic              eng_erase_err,
  input  logic              eng_clr_status,
  output logic              rewrite_en,
  output logic              blk_wr_en,
  output logic              stop_req,
  output logic              flash_rst_pulse
);
  import fctl_pkg::*;

  logic acc, hit_wr;
  logic [N_GUARD-1:0] g_q, g_qn, g_wbit, g_pre, g_fclr;
  logic [N_ERR-1:0]   e_q, e_set;
  logic stop_q;
  logic unused_wd;

  assign acc       = bus_wr | bus_rd;
  assign hit_wr    = bus_wr && (bus_addr == CTL_ADDR);
  assign unused_wd = ^{bus_wdata[7:4], bus_wdata[RDY_B]};

  assign g_wbit = {bus_wdata[BLK_B], bus_wdata[RW_B]};
  assign g_pre  = {g_q[0], 1'b1};
  assign g_fclr = {~g_qn[0], 1'b0};

  for (genvar gi = 0; gi < N_GUARD; gi++) begin : g_guard
    fctl_guard_bit u_bit (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .hit_wr   (hit_wr),
      .wbit     (g_wbit[gi]),
      .precond  (g_pre[gi]),
      .force_clr(g_fclr[gi]),
      .q        (g_q[gi]),
      .q_next   (g_qn[gi])
    );
  end

  assign e_set = {eng_erase_err, eng_prog_err};

  for (genvar ei = 0; ei < N_ERR; ei++) begin : g_err
    fctl_sticky u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (e_set[ei]),
      .clr  (eng_clr_status),
      .q    (e_q[ei])
    );
  end

  fctl_stop_unit u_stop (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_wr   (hit_wr),
    .wbit     (bus_wdata[STP_B]),
    .rw_q     (g_q[0]),
    .rw_next  (g_qn[0]),
    .stop_q   (stop_q),
    .stop_req (stop_req),
    .rst_pulse(flash_rst_pulse)
  );

  always_comb begin
    bus_rdata         = '0;
    bus_rdata[RDY_B]  = ~eng_busy;
    bus_rdata[RW_B]   = g_q[0];
    bus_rdata[BLK_B]  = g_q[1];
    bus_rdata[STP_B]  = stop_q;
    bus_rdata[PERR_B] = e_q[0];
    bus_rdata[EERR_B] = e_q[1];
  end

  assign rewrite_en = g_q[0];
  assign blk_wr_en  = g_q[1];
endmodule

// File: rtl/fctl_reg_chk.sv
module fctl_reg_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h3A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              wd_rw,
  input logic              perr_bit,
  input logic              eng_prog_err,
  input logic              rewrite_en,
  input logic              blk_wr_en,
  input logic              stop_req,
  input logic              flash_rst_pulse
);
  AST_RW_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rewrite_en) |-> $past(bus_wr && bus_addr == CTL_ADDR && wd_rw)); // R3
  AST_BLK_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wr_en |-> rewrite_en); // R6
  AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> rewrite_en); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flash_rst_pulse |=> !flash_rst_pulse); // R8
  AST_PERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_prog_err |=> perr_bit); // R9
  AST_FOREIGN_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == CTL_ADDR) |=> $stable(rewrite_en)); // R11
endmodule

bind flash_ctl_reg fctl_reg_chk #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_addr       (bus_addr),
  .bus_wr         (bus_wr),
  .wd_rw          (bus_wdata[1]),
  .perr_bit       (bus_rdata[6]),
  .eng_prog_err   (eng_prog_err),
  .rewrite_en     (rewrite_en),
  .blk_wr_en      (blk_wr_en),
  .stop_req       (stop_req),
  .flash_rst_pulse(flash_rst_pulse)
);

// File: tb/flash_ctl_reg_bench.sv
module flash_ctl_reg_bench;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A = 8'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic eng_busy = 1'b0, eng_prog_err = 1'b0, eng_erase_err = 1'b0, eng_clr_status = 1'b0;
  logic rewrite_en, blk_wr_en, stop_req, flash_rst_pulse;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expected state
  logic m_rw, m_blk, m_stop, m_pulse, m_perr, m_eerr, m_arm1, m_arm2;

  always #4 clk = ~clk;

  flash_ctl_reg #(.ADDR_W(ADDR_W), .CTL_ADDR(A)) u_flash_ctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
    .eng_prog_err(eng_prog_err), .eng_erase_err(eng_erase_err),
    .eng_clr_status(eng_clr_status), .rewrite_en(rewrite_en), .blk_wr_en(blk_wr_en),
    .stop_req(stop_req), .flash_rst_pulse(flash_rst_pulse)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(logic busy);
    return {m_eerr, m_perr, 2'b00, m_stop, m_blk, m_rw, ~busy};
  endfunction

  task automatic check_outs();
    chk("R3 rewrite_en", {7'd0, rewrite_en}, {7'd0, m_rw});
    chk("R5 blk_wr_en", {7'd0, blk_wr_en}, {7'd0, m_blk});
    chk("R7 stop_req", {7'd0, stop_req}, {7'd0, m_stop & m_rw});
    chk("R8 flash_rst_pulse", {7'd0, flash_rst_pulse}, {7'd0, m_pulse});
  endtask

  task automatic step(logic wr, logic rd, logic [ADDR_W-1:0] ad, logic [7:0] d,
                      logic busy, logic pe, logic ee, logic clr);
    logic acc, hit, rw_n, blk_n, stop_n;
    @(negedge clk);
    check_outs();
    bus_wr = wr; bus_rd = rd; bus_addr = ad; bus_wdata = d;
    eng_busy = busy; eng_prog_err = pe; eng_erase_err = ee; eng_clr_status = clr;
    #1;
    chk("R2 read data", bus_rdata, exp_read(busy));
    acc    = wr | rd;
    hit    = wr && (ad == A);
    rw_n   = hit ? (d[1] ? (m_rw | m_arm1) : 1'b0) : m_rw;
    blk_n  = hit ? (d[2] ? (m_blk | (m_arm2 & m_rw)) : 1'b0) : m_blk;
    if (!rw_n) blk_n = 1'b0;
    stop_n = hit ? d[3] : m_stop;
    @(posedge clk);
    #1;
    m_pulse = stop_n & ~m_stop & rw_n;
    m_rw = rw_n; m_blk = blk_n; m_stop = stop_n;
    m_arm1 = (hit && !d[1]) ? 1'b1 : (acc ? 1'b0 : m_arm1);
    m_arm2 = (hit && !d[2]) ? 1'b1 : (acc ? 1'b0 : m_arm2);
    m_perr = pe | (m_perr & ~clr);
    m_eerr = ee | (m_eerr & ~clr);
    bus_wr = 0; bus_rd = 0; eng_prog_err = 0; eng_erase_err = 0; eng_clr_status = 0;
  endtask

  task automatic wr(logic [7:0] d); step(1, 0, A, d, 0, 0, 0, 0); endtask
  task automatic idle(); step(0, 0, A, 8'h00, 0, 0, 0, 0); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    m_rw = 0; m_blk = 0; m_stop = 0; m_pulse = 0; m_perr = 0; m_eerr = 0; m_arm1 = 0; m_arm2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset read", bus_rdata, 8'h01);
    chk("R1 reset outs", {4'd0, rewrite_en, blk_wr_en, stop_req, flash_rst_pulse}, 8'h00);

    // R3: setting write without arming is ignored, then armed set works
    wr(8'h02);
    chk("R3 unarmed set", {7'd0, rewrite_en}, 8'h00);
    wr(8'h00); idle(); wr(8'h02);
    chk("R3 armed set across idle", {7'd0, rewrite_en}, 8'h01);
    // R4: read breaks the sequence
    wr(8'h00); step(0, 1, A, 0, 0, 0, 0, 0); wr(8'h02);
    chk("R4 read breaks arm", {7'd0, rewrite_en}, 8'h00);
    // R4/R11: foreign write breaks and does not change
    wr(8'h00); step(1, 0, A ^ 8'h01, 8'h0E, 0, 0, 0, 0); wr(8'h02);
    chk("R4 R11 foreign write", {7'd0, rewrite_en}, 8'h00);
    // R5: block enable needs rewrite mode already set
    wr(8'h00); wr(8'h06);
    chk("R5 blk same write as rw", {6'd0, blk_wr_en, rewrite_en}, 8'h01);
    wr(8'h02); wr(8'h06);
    chk("R5 blk armed", {6'd0, blk_wr_en, rewrite_en}, 8'h03);
    // R6: clearing rewrite mode clears block enable
    wr(8'h04);
    chk("R6 forced clear", {6'd0, blk_wr_en, rewrite_en}, 8'h00);
    // R7: stop outside rewrite mode reads back but is inert
    wr(8'h08);
    chk("R7 stop read back", bus_rdata & 8'h0E, 8'h08);
    chk("R7 R8 stop inert", {6'd0, stop_req, flash_rst_pulse}, 8'h00);
    // R8: stop inside rewrite mode
    wr(8'h00); wr(8'h02); wr(8'h0A);
    chk("R8 pulse", {6'd0, stop_req, flash_rst_pulse}, 8'h03);
    idle();
    chk("R8 pulse single", {6'd0, stop_req, flash_rst_pulse}, 8'h02);
    // R10: reserved bits
    wr(8'h32);
    chk("R10 reserved", bus_rdata & 8'h30, 8'h00);
    // R9: errors, clear and set-wins
    step(0, 0, A, 0, 1, 1, 1, 0);
    chk("R9 set", bus_rdata & 8'hC1, 8'hC0);
    step(0, 0, A, 0, 0, 1, 0, 1);
    chk("R9 set wins", bus_rdata & 8'hC0, 8'h40);
    step(0, 0, A, 0, 0, 0, 0, 1);
    chk("R9 clear", bus_rdata & 8'hC0, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] kind;
      logic [ADDR_W-1:0] ad;
      logic [7:0] d;
      kind = 3'($urandom_range(0, 7));
      ad = ($urandom_range(0, 1) != 0) ? A : (A ^ (8'h01 << $urandom_range(0, 7)));
      d  = 8'($urandom);
      if ($urandom_range(0, 2) == 0) d = d & 8'hF9;
      step(kind < 4, kind == 4, ad, d, 1'($urandom_range(0, 1)),
           $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0);
    end
    @(negedge clk);
    check_outs();
    finish_run();
  end
endmodule